// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 1M words by 16 bits. The RAM has active-low chip enable, output enable, write enable and a separate active-low strobe for each byte lane. The host gives one word request at a time through a request/ready handshake. Each request carries a write flag, a 2-bit byte enable, a 20-bit word address and 16-bit write data. The controller expands each request into a control sequence on the memory pins. Every phase lasts a whole number of clock cycles, and the cycle counts are parameters. Read data comes back on its own port with a one-cycle valid strobe.

A write drives the address and data first. It then opens the write window by pulling write enable and the selected byte strobes low together, and it closes the window by raising the strobes while the address and data stay put. When another write arrives at the end of a write, the controller runs a burst. Write enable stays low, and each new word is framed only by the byte strobes. A read holds output enable low for the access count. After a read, output enable stays high for a turnaround count before the controller may drive the shared data bus again.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, ready is 1, the memory controls (chip, output and write enables, upper and lower strobes) are all 1, data drive-enable is 0 and rd_valid is 0.
- R2: Host byte enable bit 0 selects data bits 7:0 through the lower strobe, and bit 1 selects bits 15:8 through the upper strobe. A write changes only the enabled lanes of the addressed word.
- R3: During a write window (write enable and at least one strobe low), chip enable is low, output enable is high, drive-enable is 1, and address and data do not change. The window lasts at least WP_CYC cycles.
- R4: Address and data are on the pins at least SETUP_CYC cycles before the strobes fall. They are still unchanged in the cycle in which the strobes rise.
- R5: A read holds chip and output enable low with write enable high. rd_valid pulses for one cycle at ACC_CYC+1 cycles after acceptance. rd_data carries the enabled lanes, and disabled lanes read as 0.
- R6: Drive-enable is never 1 while output enable is low. It rises only after output enable has been high for at least TURN_CYC cycles.
- R7: A write accepted at the end of a previous write keeps write enable low across both words. Each word gets its own strobe pulse, so a burst of N words shows one write-enable rise and N strobe falls.
- R8: A write with byte enable 00 asserts no strobe and leaves memory unchanged. A read with byte enable 00 returns 0.
- R9: ready is 1 in idle. At the end of a write, ready is 1 only while wr is 1. Otherwise ready is 0. When ready is 1, both strobes and output enable are high. Once an operation has ended, chip enable returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| ready | output | 1 | Request accepted when req and ready are 1 at a clock edge |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Byte enables, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| addr | input | 20 | Word address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, disabled lanes zero |
| rd_valid | output | 1 | One-cycle read data strobe |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_addr | output | 20 | Memory word address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned from the memory |

## Verification
A behavioural byte-lane memory in the bench samples the pins once per cycle. It measures every write window and checks the pulse width, setup, hold, turnaround and bus contention. It also holds the data that later reads return. Reads use every byte-enable pattern: full-word reads test the address path, and single-lane reads show that masking and lane order are kept apart. The directed part covers partial writes to each lane, a write with no lanes enabled and a four-word burst; write-enable rises and strobe falls are counted to tell a real burst from separate writes. Random reads and writes on a small set of addresses then mix all of these sequences, so reads following writes check that turnaround and deselect hold between operations.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WGAP,
    ST_WBSET,
    ST_RACC,
    ST_RREC
  } asram_st_e;

endpackage

// File: rtl/asram_wait_timer.sv
module asram_wait_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_lane_gate.sv
module asram_lane_gate #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]   be,
  input  logic               active,
  input  logic [8*LANES-1:0] rd_bus,
  output logic [LANES-1:0]   stb_n,
  output logic [8*LANES-1:0] rd_masked
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign stb_n[g]           = ~(be[g] & active);
    assign rd_masked[8*g +: 8] = be[g] ? rd_bus[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW        = 20,
  parameter int ACC_CYC   = 2,
  parameter int WP_CYC    = 2,
  parameter int SETUP_CYC = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          ready,
  input  logic          wr,
  input  logic [1:0]    be,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rd_data,
  output logic          rd_valid,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);

  localparam int LANES = 2;
  localparam int DW    = 8 * LANES;
  localparam int MAX_AB = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int MAX_CD = (SETUP_CYC > TURN_CYC) ? SETUP_CYC : TURN_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] ACC_LD  = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] WP_LD   = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] SET_LD  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);

  asram_st_e st_q, st_d;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_exp;

  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_q;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q;
  logic             accept;
  logic             rd_cap;
  logic             lane_active;
  logic [LANES-1:0] stb_n;
  logic [DW-1:0]    rd_masked;

  asram_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  asram_lane_gate #(.LANES(LANES)) u_lanes (
    .be        (be_q),
    .active    (lane_active),
    .rd_bus    (mem_dq_in),
    .stb_n     (stb_n),
    .rd_masked (rd_masked)
  );

  // Handshake: idle takes any request, the write gap only a write.
  assign ready  = (st_q == ST_IDLE) || ((st_q == ST_WGAP) && wr);
  assign accept = req && ready;
  assign rd_cap = (st_q == ST_RACC) && tmr_exp;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d     = wr ? ST_WSET : ST_RACC;
          tmr_load = 1'b1;
          tmr_val  = wr ? SET_LD : ACC_LD;
        end
      end
      ST_WSET, ST_WBSET: begin
        if (tmr_exp) begin
          st_d     = ST_WPUL;
          tmr_load = 1'b1;
          tmr_val  = WP_LD;
        end
      end
      ST_WPUL: begin
        if (tmr_exp) st_d = ST_WGAP;
      end
      ST_WGAP: begin
        if (req && wr) begin
          st_d     = ST_WBSET;
          tmr_load = 1'b1;
          tmr_val  = SET_LD;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_RACC: begin
        if (tmr_exp) begin
          st_d     = ST_RREC;
          tmr_load = 1'b1;
          tmr_val  = TURN_LD;
        end
      end
      ST_RREC: begin
        if (tmr_exp) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rvalid_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      rvalid_q <= rd_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= addr;
      wdata_q <= wdata;
      be_q    <= be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_cap) begin
      rdata_q <= rd_masked;
    end
  end

  // Pin decode from the state register.
  assign lane_active = (st_q == ST_WPUL) || (st_q == ST_RACC);
  assign mem_ce_n    = (st_q == ST_IDLE) || (st_q == ST_RREC);
  assign mem_oe_n    = (st_q != ST_RACC);
  assign mem_we_n    = !((st_q == ST_WPUL) || (st_q == ST_WGAP) || (st_q == ST_WBSET));
  assign mem_dq_oe   = (st_q == ST_WSET) || (st_q == ST_WPUL) ||
                       (st_q == ST_WGAP) || (st_q == ST_WBSET);
  assign mem_ub_n    = stb_n[1];
  assign mem_lb_n    = stb_n[0];
  assign mem_addr    = addr_q;
  assign mem_dq_out  = wdata_q;
  assign rd_data     = rdata_q;
  assign rd_valid    = rvalid_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rd_valid,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_dq_out,
  input logic          mem_dq_oe
);

  assert_wr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !(mem_ub_n && mem_lb_n)) |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  assert_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ub_n && mem_lb_n) && mem_oe_n) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ub_n && mem_lb_n) && !mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_read_ctl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  assert_rvalid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ub_n && mem_lb_n && mem_oe_n));

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .rd_valid   (rd_valid),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_ub_n   (mem_ub_n),
  .mem_lb_n   (mem_lb_n),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;

  localparam int CLK_NS    = 10;
  localparam int ACC_CYC   = 2;
  localparam int WP_CYC    = 2;
  localparam int TURN_CYC  = 1;
  localparam int NIDX      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ready, rd_valid;
  logic [15:0] rd_data;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_fail = 0;

  asram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr(wr), .be(be),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [15:0] d, input logic [1:0] b);
    return {b[1] ? d[15:8] : 8'h00, b[0] ? d[7:0] : 8'h00};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n, input logic [1:0] b);
    return {b[1] ? n[15:8] : o[15:8], b[0] ? n[7:0] : o[7:0]};
  endfunction

  function automatic logic [19:0] idx_addr(input int i);
    return {12'(i * 173 + 5), 8'(i)};
  endfunction

  // Behavioural byte-lane memory, sampled once per cycle at the falling edge.
  logic [15:0] md [256];
  logic [11:0] mt [256];
  logic [15:0] ref_d [NIDX];
  logic        rd_act, tag_ok;

  assign rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign tag_ok = (mt[mem_addr[7:0]] == mem_addr[19:8]);
  assign mem_dq_in = {(!rd_act || mem_ub_n) ? 8'h5A : (tag_ok ? md[mem_addr[7:0]][15:8] : 8'hBA),
                      (!rd_act || mem_lb_n) ? 8'h5A : (tag_ok ? md[mem_addr[7:0]][7:0]  : 8'hD0)};

  logic        win, win_q = 1'b0, oe_q = 1'b0, we_q = 1'b1, stb_q = 1'b0;
  logic [19:0] p_addr = '0, w_addr = '0;
  logic [15:0] p_data = '0, w_data = '0;
  logic [1:0]  w_ln = '0;
  int          wcnt = 0, oe_hi = 1000, we_rise = 0, stb_fall = 0;

  initial begin
    for (int k = 0; k < 256; k++) begin
      md[k] = '0;
      mt[k] = '0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      win = !mem_ce_n && !mem_we_n && !(mem_ub_n && mem_lb_n);
      if (win) begin
        if (!win_q) begin
          wcnt   = 1;
          w_addr = mem_addr;
          w_data = mem_dq_out;
          w_ln   = {!mem_ub_n, !mem_lb_n};
          if (mem_addr !== p_addr || !oe_q || mem_dq_out !== p_data)
            chk(1'b0, "R4 setup before strobe", mem_addr, p_addr);
        end else begin
          wcnt++;
          if (mem_addr !== w_addr || mem_dq_out !== w_data || !mem_dq_oe || !mem_oe_n)
            chk(1'b0, "R3 window stability", mem_addr, w_addr);
        end
      end else if (win_q) begin
        chk(wcnt >= WP_CYC, "R3 write pulse width", wcnt, WP_CYC);
        chk(mem_addr === w_addr && mem_dq_out === w_data && mem_dq_oe, "R4 hold after strobe", mem_addr, w_addr);
        if (w_ln[0]) md[w_addr[7:0]][7:0]  = w_data[7:0];
        if (w_ln[1]) md[w_addr[7:0]][15:8] = w_data[15:8];
        mt[w_addr[7:0]] = w_addr[19:8];
      end
      if (mem_dq_oe && !oe_q)
        chk(oe_hi >= TURN_CYC, "R6 turnaround before drive", oe_hi, TURN_CYC);
      if (mem_dq_oe && !mem_oe_n && !mem_ce_n)
        chk(1'b0, "R6 bus contention", 1, 0);
      oe_hi = mem_oe_n ? oe_hi + 1 : 0;
      if (mem_we_n && !we_q) we_rise++;
      if (!(mem_ub_n && mem_lb_n) && stb_q) stb_fall++;
      win_q  = win;
      oe_q   = mem_dq_oe;
      we_q   = mem_we_n;
      stb_q  = mem_ub_n && mem_lb_n;
      p_addr = mem_addr;
      p_data = mem_dq_out;
    end
  end

  // Host tasks: called at a falling edge, return at a falling edge.
  task automatic host_write(input int i, input logic [1:0] b, input logic [15:0] d, input bit hold);
    req = 1'b1; wr = 1'b1; be = b; addr = idx_addr(i); wdata = d;
    for (int t = 0; t < 40 && !ready; t++) @(negedge clk);
    @(negedge clk);
    if (!hold) req = 1'b0;
    ref_d[i] = merge(ref_d[i], d, b);
  endtask

  task automatic host_read(input int i, input logic [1:0] b, input string tag);
    int lat;
    req = 1'b1; wr = 1'b0; be = b; addr = idx_addr(i);
    for (int t = 0; t < 40 && !ready; t++) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    if (ready) chk(1'b0, "R9 ready low during read", ready, 0);
    while (!rd_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == ACC_CYC + 1, "R5 read latency", lat, ACC_CYC + 1);
    chk(rd_data === lane_mask(ref_d[i], b), tag, rd_data, lane_mask(ref_d[i], b));
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int wr0, sf0;
    logic [31:0] r;
    void'($urandom(32'd1234));
    for (int k = 0; k < NIDX; k++) ref_d[k] = '0;

    repeat (3) @(negedge clk);
    chk(ready === 1'b1, "R1 ready in reset", ready, 1);
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rd_valid} === 7'b1111100,
        "R1 pins in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rd_valid}, 7'b1111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ready, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rd_valid} === 8'b11111100,
        "R1 pins after release", {ready, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rd_valid}, 8'b11111100);

    // Fill every test word with full writes.
    for (int k = 0; k < NIDX; k++) host_write(k, 2'b11, 16'(k * 16'h1111 + 16'h0F0F), 1'b0);
    host_read(3, 2'b11, "R2 full word read");

    // Partial lanes.
    host_write(4, 2'b01, 16'hAB12, 1'b0);
    host_read(4, 2'b11, "R2 lower lane write only");
    host_write(5, 2'b10, 16'h34CD, 1'b0);
    host_read(5, 2'b11, "R2 upper lane write only");
    host_read(5, 2'b01, "R5 lower lane read, upper zero");
    host_read(5, 2'b10, "R5 upper lane read, lower zero");

    // No lanes enabled.
    host_write(6, 2'b00, 16'hFFFF, 1'b0);
    host_read(6, 2'b11, "R8 empty write leaves word");
    host_read(6, 2'b00, "R8 empty read returns zero");

    // Burst of four words.
    repeat (2) @(negedge clk);
    wr0 = we_rise;
    sf0 = stb_fall;
    host_write(8, 2'b11, 16'h1001, 1'b1);
    host_write(9, 2'b01, 16'h2002, 1'b1);
    host_write(10, 2'b10, 16'h3003, 1'b1);
    host_write(11, 2'b11, 16'h4004, 1'b0);
    repeat (6) @(negedge clk);
    chk(we_rise - wr0 == 1, "R7 burst keeps write enable low", we_rise - wr0, 1);
    chk(stb_fall - sf0 == 4, "R7 burst strobe pulses", stb_fall - sf0, 4);
    chk(mem_ce_n === 1'b1 && ready === 1'b1, "R9 deselect after burst", {mem_ce_n, ready}, 2'b11);
    for (int k = 8; k < 12; k++) host_read(k, 2'b11, "R7 burst data");

    // Random mix.
    for (int n = 0; n < 120; n++) begin
      r = $urandom;
      if (r[8]) host_write(int'(r[3:0]), r[5:4], 16'($urandom), r[9] & r[10]);
      else      host_read(int'(r[3:0]), r[5:4], "R2 random read-back");
    end
    req = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 0; k < NIDX; k++) host_read(k, 2'b11, "R2 final sweep");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule